// File: doc/BRIEF.md
# Single-Cycle Core with Link and Indirect Jumps

This block is a compact single-cycle processor core for a 32-bit load/store instruction set. Each instruction is fetched, decoded, executed and retired in one clock. The base subset covers register add and subtract, word load, word store, branch-if-equal and the absolute jump. Three extensions sit on top of it: a call jump that leaves its return address in register 31, a load whose address is the sum of two registers, and an indirect jump that takes its new program counter from a data-memory word.

The core holds its program counter, a 32-entry by 32-bit register file, and word-wide instruction and data memories. A load port fills both memories while reset is held. Three selects drive the datapath, and each is two bits wide. The destination select chooses rt, rd or the constant 31. The write-back select chooses the ALU result, memory data or PC+4. The next-PC select chooses the sequential or branch address, the jump target or memory data. Every register-file write and data-memory write that the core commits appears on the observation outputs in the same cycle, together with the current PC.

Top module: `slc_link_core`

## Requirements
- R1: While rst_n is low, and for the two clock edges after it rises, pc_o is 0 and neither rf_we_o nor dm_we_o is asserted. Taking rst_n low forces pc_o to 0 at once. Memory contents written through the load port survive a reset.
- R2: Opcode 000000 with funct 100000 writes R[rs]+R[rt] to rd. With funct 100010 it writes R[rs]-R[rt] to rd. The PC then advances by 4.
- R3: Opcode 100011 loads the word at R[rs]+SignExt(imm16) into rt. Opcode 101011 stores R[rt] to that byte address and shows it on dm_we_o, dm_addr_o and dm_wdata_o. Bits [1:0] of an address are ignored.
- R4: Opcode 000100 sets the PC to PC+4+(SignExt(imm16)<<2) when R[rs]==R[rt], and to PC+4 otherwise. Negative offsets are included.
- R5: Opcode 000010 sets the PC to {PC+4[31:28], target[25:0], 2'b00} and writes nothing.
- R6: Opcode 000011 writes PC+4 to register 31 and jumps to the same target as R5, both in one cycle.
- R7: Opcode 000000 with funct 101101 loads the word at R[rt]+R[rs] into rd.
- R8: Opcode 010100 sets the PC to the data word at R[rs]+SignExt(imm16). It writes neither a register nor memory.
- R9: Register 0 reads as zero. A write aimed at it is dropped and raises no rf_we_o.
- R10: Any other opcode writes nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| prog_we | input | 1 | Load-port write strobe |
| prog_to_dmem | input | 1 | Load-port target: 1 data memory, 0 instruction memory |
| prog_addr | input | 32 | Load-port byte address |
| prog_data | input | 32 | Load-port write word |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | A register write is committed this cycle |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value written |
| dm_we_o | output | 1 | A data-memory store is committed this cycle |
| dm_addr_o | output | 32 | Store byte address |
| dm_wdata_o | output | 32 | Store data |

## Verification
A single program is run from reset, and the PC and write trace are compared cycle by cycle. It uses data words loaded in advance, so sums, a negative difference and a register-indexed load address each yield a unique value. This shows which destination select and which write-back source were taken. The program also contains an untaken branch, a taken forward branch, a self-looping backward branch, the call jump, the memory-indirect jump and an absolute jump. Instructions that a wrong next-PC choice would execute write a marker register that appears in the trace. Writes aimed at register 0, unknown opcodes and a mid-run reset are all checked only at the ports.

// File: rtl/slc_pkg.sv
package slc_pkg;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] OP_JAL   = 6'b000011;
  localparam logic [5:0] OP_JMEM  = 6'b010100;

  localparam logic [5:0] FN_ADD   = 6'b100000;
  localparam logic [5:0] FN_SUB   = 6'b100010;
  localparam logic [5:0] FN_LDX   = 6'b101101;

  localparam logic [4:0] LINK_REG = 5'd31;

  typedef enum logic [1:0] {DST_RT = 2'b00, DST_RD = 2'b01, DST_LINK = 2'b10} dst_sel_e;
  typedef enum logic [1:0] {WB_ALU = 2'b00, WB_MEM = 2'b01, WB_LINK = 2'b10} wb_sel_e;
  typedef enum logic [1:0] {PC_SEQ = 2'b00, PC_JTGT = 2'b01, PC_MEM = 2'b10} pc_sel_e;
  typedef enum logic {ALU_ADD = 1'b0, ALU_SUB = 1'b1} alu_fn_e;

  typedef struct packed {
    dst_sel_e   dst_sel;
    logic       alu_imm;
    wb_sel_e    wb_sel;
    logic       reg_write;
    logic       mem_read;
    logic       mem_write;
    logic       branch;
    logic [1:0] alu_op;
    pc_sel_e    pc_sel;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{
    dst_sel: DST_RT, alu_imm: 1'b0, wb_sel: WB_ALU, reg_write: 1'b0,
    mem_read: 1'b0, mem_write: 1'b0, branch: 1'b0, alu_op: 2'b00, pc_sel: PC_SEQ
  };

endpackage

// File: rtl/slc_decode.sv
module slc_decode
  import slc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_fn_e    alu_fn
);

  always_comb begin
    ctrl = CTRL_IDLE;
    unique case (opcode)
      OP_RTYPE: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          ctrl.dst_sel   = DST_RD;
          ctrl.reg_write = 1'b1;
          ctrl.alu_op    = 2'b10;
        end else if (funct == FN_LDX) begin
          ctrl.dst_sel   = DST_RD;
          ctrl.wb_sel    = WB_MEM;
          ctrl.reg_write = 1'b1;
          ctrl.mem_read  = 1'b1;
        end
      end
      OP_LW: begin
        ctrl.alu_imm   = 1'b1;
        ctrl.wb_sel    = WB_MEM;
        ctrl.reg_write = 1'b1;
        ctrl.mem_read  = 1'b1;
      end
      OP_SW: begin
        ctrl.alu_imm   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = 2'b01;
      end
      OP_J: begin
        ctrl.pc_sel = PC_JTGT;
      end
      OP_JAL: begin
        ctrl.dst_sel   = DST_LINK;
        ctrl.wb_sel    = WB_LINK;
        ctrl.reg_write = 1'b1;
        ctrl.pc_sel    = PC_JTGT;
      end
      OP_JMEM: begin
        ctrl.alu_imm  = 1'b1;
        ctrl.mem_read = 1'b1;
        ctrl.pc_sel   = PC_MEM;
      end
      default: ctrl = CTRL_IDLE;
    endcase
  end

  always_comb begin
    unique case (ctrl.alu_op)
      2'b01:   alu_fn = ALU_SUB;
      2'b10:   alu_fn = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
      default: alu_fn = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/slc_regfile.sv
module slc_regfile #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_b,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata
);

  logic [WIDTH-1:0] regs_q [DEPTH];
  logic             wr_en;

  assign wr_en = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_en) regs_q[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];

  AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (regs_q[$past(waddr)] == $past(wdata))); // R2

endmodule

// File: rtl/slc_wordmem.sv
module slc_wordmem #(
  parameter int WORDS = 64,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] cells_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) cells_q[waddr] <= wdata;
  end

  assign rdata = cells_q[raddr];

endmodule

// File: rtl/slc_link_core.sv
module slc_link_core
  import slc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IA_W = $clog2(IMEM_WORDS),
  localparam int DA_W = $clog2(DMEM_WORDS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prog_we,
  input  logic        prog_to_dmem,
  input  logic [31:0] prog_addr,
  input  logic [31:0] prog_data,
  output logic [31:0] pc_o,
  output logic        rf_we_o,
  output logic [4:0]  rf_waddr_o,
  output logic [31:0] rf_wdata_o,
  output logic        dm_we_o,
  output logic [31:0] dm_addr_o,
  output logic [31:0] dm_wdata_o
);

  // reset release synchronizer
  logic [1:0] rsync_q;
  logic       run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign run = rsync_q[1];

  // program counter
  logic [31:0] pc_q, pc_d, pc4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pc_q <= '0;
    else if (run) pc_q <= pc_d;
  end
  assign pc4 = pc_q + 32'd4;

  // fetch
  logic [31:0] instr;

  slc_wordmem #(.WORDS(IMEM_WORDS), .WIDTH(32)) imem_i (
    .clk   (clk),
    .we    (prog_we && !prog_to_dmem),
    .waddr (prog_addr[IA_W+1:2]),
    .wdata (prog_data),
    .raddr (pc_q[IA_W+1:2]),
    .rdata (instr)
  );

  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd;
  logic [15:0] imm16;
  logic [25:0] jtarget;
  logic [31:0] sext;

  assign opcode  = instr[31:26];
  assign rs      = instr[25:21];
  assign rt      = instr[20:16];
  assign rd      = instr[15:11];
  assign funct   = instr[5:0];
  assign imm16   = instr[15:0];
  assign jtarget = instr[25:0];
  assign sext    = {{16{imm16[15]}}, imm16};

  // decode
  ctrl_t   ctrl;
  alu_fn_e alu_fn;

  slc_decode dec_i (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl),
    .alu_fn (alu_fn)
  );

  // register file
  logic [31:0] rs_val, rt_val, wb_val;
  logic [4:0]  dst;
  logic        rf_we;

  always_comb begin
    unique case (ctrl.dst_sel)
      DST_RD:   dst = rd;
      DST_LINK: dst = LINK_REG;
      default:  dst = rt;
    endcase
  end

  assign rf_we = run && ctrl.reg_write;

  slc_regfile #(.DEPTH(32), .WIDTH(32)) rf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .raddr_a (rs),
    .rdata_a (rs_val),
    .raddr_b (rt),
    .rdata_b (rt_val),
    .we      (rf_we),
    .waddr   (dst),
    .wdata   (wb_val)
  );

  // execute
  logic [31:0] alu_b, alu_y;
  logic        alu_zero;

  assign alu_b = ctrl.alu_imm ? sext : rt_val;

  always_comb begin
    unique case (alu_fn)
      ALU_SUB: alu_y = rs_val - alu_b;
      default: alu_y = rs_val + alu_b;
    endcase
  end
  assign alu_zero = (alu_y == '0);

  // data memory
  logic [31:0] dm_raw, dm_rdata;
  logic        core_st;
  logic        dm_we;
  logic [DA_W-1:0] dm_widx;
  logic [31:0] dm_wword;

  assign core_st  = run && ctrl.mem_write;
  assign dm_we    = (prog_we && prog_to_dmem) || core_st;
  assign dm_widx  = (prog_we && prog_to_dmem) ? prog_addr[DA_W+1:2] : alu_y[DA_W+1:2];
  assign dm_wword = (prog_we && prog_to_dmem) ? prog_data : rt_val;

  slc_wordmem #(.WORDS(DMEM_WORDS), .WIDTH(32)) dmem_i (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_widx),
    .wdata (dm_wword),
    .raddr (alu_y[DA_W+1:2]),
    .rdata (dm_raw)
  );

  assign dm_rdata = ctrl.mem_read ? dm_raw : '0;

  // write-back
  always_comb begin
    unique case (ctrl.wb_sel)
      WB_MEM:  wb_val = dm_rdata;
      WB_LINK: wb_val = pc4;
      default: wb_val = alu_y;
    endcase
  end

  // next PC
  logic [31:0] br_tgt, seq_pc, jmp_tgt;

  assign br_tgt  = pc4 + {sext[29:0], 2'b00};
  assign seq_pc  = (ctrl.branch && alu_zero) ? br_tgt : pc4;
  assign jmp_tgt = {pc4[31:28], jtarget, 2'b00};

  always_comb begin
    unique case (ctrl.pc_sel)
      PC_JTGT: pc_d = jmp_tgt;
      PC_MEM:  pc_d = dm_rdata;
      default: pc_d = seq_pc;
    endcase
  end

  // observation
  assign pc_o       = pc_q;
  assign rf_we_o    = rf_we && (dst != 5'd0);
  assign rf_waddr_o = dst;
  assign rf_wdata_o = wb_val;
  assign dm_we_o    = core_st;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

  logic unused_bits;
  assign unused_bits = ^{prog_addr, instr[10:6], pc_q[1:0]};

  AST_JAL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && opcode == OP_JAL) |-> (rf_we_o && rf_waddr_o == LINK_REG && rf_wdata_o == pc_q + 32'd4)); // R6
  AST_JAL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (run && opcode == OP_JAL) |=> (pc_q == {$past(pc4[31:28]), $past(jtarget), 2'b00})); // R6
  AST_JMEM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (run && opcode == OP_JMEM) |-> (!rf_we_o && !dm_we_o)); // R8
  AST_JMEM_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (run && opcode == OP_JMEM) |=> (pc_q == $past(dm_raw))); // R8
  AST_ALU_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (run && opcode == OP_RTYPE) |=> (pc_q == $past(pc_q) + 32'd4)); // R2
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!rf_we_o && !dm_we_o && pc_q == '0)); // R1

endmodule

// File: tb/slc_link_core_tb.sv
`timescale 1ns/1ps
module slc_link_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        prog_we, prog_to_dmem;
  logic [31:0] prog_addr, prog_data;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [4:0]  rf_waddr_o;
  logic        rf_we_o, dm_we_o;

  always #2.5 clk = ~clk;

  slc_link_core dut_i (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_to_dmem(prog_to_dmem),
    .prog_addr(prog_addr), .prog_data(prog_data), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  localparam logic [31:0] FILL = 32'h00213020; // add r6,r1,r1 : marker write r6=10

  localparam logic [31:0] PROG [24] = '{
    32'h8C010000, // 00 lw  r1,0(r0)
    32'h8C020004, // 04 lw  r2,4(r0)
    32'h00221820, // 08 add r3,r1,r2
    32'h00412022, // 0C sub r4,r2,r1
    32'h0022282D, // 10 ldx r5,r1,r2
    32'hAC050010, // 14 sw  r5,16(r0)
    32'h10220005, // 18 beq r1,r2,+5 (not taken)
    32'h10630001, // 1C beq r3,r3,+1 (taken)
    FILL, // 20
    32'h0C00000C, // 24 jal 0x30
    FILL, FILL,   // 28 2C
    32'h50000008, // 30 jmem 8(r0)
    FILL, FILL, FILL, // 34 38 3C
    32'h08000012, // 40 j 0x48
    FILL,         // 44
    32'h00220020, // 48 add r0,r1,r2
    32'hAC000014, // 4C sw  r0,20(r0)
    32'hFC011234, // 50 unknown opcode
    32'hAC1F0018, // 54 sw  r31,24(r0)
    32'h00223822, // 58 sub r7,r1,r2
    32'h1000FFFF  // 5C beq r0,r0,-1
  };

  localparam logic [31:0] DATA [4] = '{32'd5, 32'd7, 32'h40, 32'h99};

  typedef struct packed {
    logic [31:0] pc;
    logic        rwe;
    logic [4:0]  ra;
    logic [31:0] rd;
    logic        mwe;
    logic [31:0] ma;
    logic [31:0] md;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{32'h00, 1'b1, 5'd1,  32'd5,        1'b0, 32'd0,  32'd0},   // R3
    '{32'h04, 1'b1, 5'd2,  32'd7,        1'b0, 32'd0,  32'd0},   // R3
    '{32'h08, 1'b1, 5'd3,  32'd12,       1'b0, 32'd0,  32'd0},   // R2
    '{32'h0C, 1'b1, 5'd4,  32'd2,        1'b0, 32'd0,  32'd0},   // R2
    '{32'h10, 1'b1, 5'd5,  32'h99,       1'b0, 32'd0,  32'd0},   // R7
    '{32'h14, 1'b0, 5'd0,  32'd0,        1'b1, 32'd16, 32'h99},  // R3
    '{32'h18, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0},   // R4
    '{32'h1C, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0},   // R4
    '{32'h24, 1'b1, 5'd31, 32'h28,       1'b0, 32'd0,  32'd0},   // R6
    '{32'h30, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0},   // R8
    '{32'h40, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0},   // R5
    '{32'h48, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0},   // R9
    '{32'h4C, 1'b0, 5'd0,  32'd0,        1'b1, 32'd20, 32'd0},   // R9
    '{32'h50, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0},   // R10
    '{32'h54, 1'b0, 5'd0,  32'd0,        1'b1, 32'd24, 32'h28},  // R6
    '{32'h58, 1'b1, 5'd7,  32'hFFFFFFFE, 1'b0, 32'd0,  32'd0},   // R2
    '{32'h5C, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0},   // R4
    '{32'h5C, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0},   // R4
    '{32'h5C, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0}    // R4
  };

  function automatic string vtag(int i);
    case (i)
      0, 1, 5: return "R3";
      2, 3, 15: return "R2";
      4:        return "R7";
      8, 14:    return "R6";
      9:        return "R8";
      10:       return "R5";
      11, 12:   return "R9";
      13:       return "R10";
      default:  return "R4";
    endcase
  endfunction

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic release_reset();
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0; prog_we = 1'b0; prog_to_dmem = 1'b0; prog_addr = '0; prog_data = '0;
    repeat (2) @(negedge clk);
    chk("R1", "pc in reset", pc_o, 32'h0);

    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_to_dmem = 1'b0; prog_addr = 32'(i * 4);
      prog_data = (i < 24) ? PROG[i] : FILL;
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_to_dmem = 1'b1; prog_addr = 32'(i * 4); prog_data = DATA[i];
    end
    @(negedge clk) prog_we = 1'b0;
    @(negedge clk);
    // first word is a load, yet nothing may commit under reset
    chk("R1", "rf_we under reset", {31'd0, rf_we_o}, 32'd0);
    chk("R1", "dm_we under reset", {31'd0, dm_we_o}, 32'd0);

    release_reset();
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      chk(vtag(i), $sformatf("pc v%0d", i), pc_o, VEC[i].pc);
      chk(vtag(i), $sformatf("rf_we v%0d", i), {31'd0, rf_we_o}, {31'd0, VEC[i].rwe});
      if (VEC[i].rwe) begin
        chk(vtag(i), $sformatf("rf_waddr v%0d", i), {27'd0, rf_waddr_o}, {27'd0, VEC[i].ra});
        chk(vtag(i), $sformatf("rf_wdata v%0d", i), rf_wdata_o, VEC[i].rd);
      end
      chk(vtag(i), $sformatf("dm_we v%0d", i), {31'd0, dm_we_o}, {31'd0, VEC[i].mwe});
      if (VEC[i].mwe) begin
        chk(vtag(i), $sformatf("dm_addr v%0d", i), dm_addr_o, VEC[i].ma);
        chk(vtag(i), $sformatf("dm_wdata v%0d", i), dm_wdata_o, VEC[i].md);
      end
    end

    // asynchronous reset in mid-run
    rst_n = 1'b0;
    #1;
    chk("R1", "pc after async reset", pc_o, 32'h0);
    chk("R1", "rf_we after async reset", {31'd0, rf_we_o}, 32'd0);

    // restart: preloaded data must still be there
    release_reset();
    @(negedge clk);
    chk("R1", "pc after restart", pc_o, 32'h0);
    chk("R3", "reload r1 after restart", rf_wdata_o, 32'd5);
    @(negedge clk);
    chk("R3", "second cycle pc", pc_o, 32'h4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule